// File: doc/BRIEF.md
# Flash Write-Status Readback Generator

This block forms the byte a flash bank presents on a shared memory bus. A flash bank with its own program and erase engine shares address, data and strobe lines with an SRAM bank, and each bank has its own active-low enable. When the flash engine is idle, the block passes the array byte through to the bus. While an internal program or erase is running, it replaces the array byte with a status byte that software polls to find out when the write has finished.

Two status bits are produced. The polling bit carries the complement of the bit being programmed during a program, and 0 during an erase. The toggle bit alternates between successive reads for as long as the engine is busy. The block also settles which bank owns a bus cycle when both enables are low, and it tells the SRAM side when that bank is addressed. The array storage and the command decoder are outside this block. They supply the array byte, the busy flag, the operation type and the polling bit of the byte being programmed.

Top module: `flash_status_rdbk`

## Requirements
- R1: The output enable `dq_oe` is 1 only when `flash_en_n` is 0, `oe_n` is 0 and `we_n` is 1. Whenever `oe_n` is 1 or `we_n` is 0, `dq_oe` is 0. Whenever `dq_oe` is 0, `dq_out` is all zeros.
- R2: When both enables are 0, the flash bank owns the cycle: a flash read is served and `sram_sel` stays 0.
- R3: `sram_sel` is 1 only when `sram_en_n` is 0, `flash_en_n` is 1 and the address is below `SRAM_BYTES` (default 128 KiB, so addresses 0x00000 to 0x1FFFF). An address of 0x20000 or above gives `sram_sel` 0.
- R4: When `busy` is 0, a flash read returns `array_data` unchanged on `dq_out`.
- R5: When `busy` is 1 and `busy_op` is 0 (program), bit 7 of a flash read is the inverse of `prog_msb`.
- R6: When `busy` is 1 and `busy_op` is 1 (erase), bit 7 of a flash read is 0.
- R7: When `busy` is 1, bit 6 of a flash read takes the opposite value on each successive flash read. A read held for many cycles shows a constant value, and it changes state only when the read strobe ends while `busy` is 1. Reads made while idle leave the toggle state unchanged.
- R8: When `busy` is 1, every bit of a flash read other than bits 7 and 6 is 0.
- R9: The first flash read after `busy` returns to 0 gives the full `array_data`, with no status bits.
- R10: After reset, the first busy read shows bit 6 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the read strobe |
| rst_n | input | 1 | Active-low asynchronous reset |
| flash_en_n | input | 1 | Flash bank enable, active low |
| sram_en_n | input | 1 | SRAM bank enable, active low |
| oe_n | input | 1 | Output strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Shared byte address |
| busy | input | 1 | Flash engine is running a program or erase |
| busy_op | input | 1 | Type of the running operation: 0 = program, 1 = erase |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| array_data | input | DATA_W | Byte read from the flash array |
| dq_out | output | DATA_W | Data driven toward the bus pads |
| dq_oe | output | 1 | Pad output enable (pads are high impedance when 0) |
| sram_sel | output | 1 | SRAM bank is selected for this cycle |

## Verification
Reads are issued with the engine idle, during a program with each polling value, and during an erase. Each pattern separates pass-through data from the status byte and shows which of the two polling rules is in force. A chain of short reads separates a toggle that advances once per access from one that stays put. A single read held for several cycles separates an advance on the end of the access from an advance on every clock. Strobe and enable combinations (output strobe high, write strobe low, both enables low, and SRAM addresses on either side of the 128 KiB boundary) separate correct bank ownership and pad gating from the wrong ones. Idle reads placed between busy phases show that the toggle freezes when the engine is not running.

// File: rtl/flash_status_pkg.sv
`timescale 1ns/1ps
package flash_status_pkg;
   typedef enum logic {
      OP_PROGRAM = 1'b0,
      OP_ERASE   = 1'b1
   } busy_op_e;
endpackage

// File: rtl/fs_enable_arb.sv
`timescale 1ns/1ps
module fs_enable_arb #(
   parameter int ADDR_W     = 18,
   parameter int SRAM_BYTES = 131072
) (
   input  logic              flash_en_n,
   input  logic              sram_en_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              flash_rd,
   output logic              sram_sel
);
   localparam longint SPACE = longint'(1) << ADDR_W;
   logic in_window;

   generate
      if (longint'(SRAM_BYTES) >= SPACE) begin : g_full_window
         logic unused_addr;
         assign unused_addr = ^addr;
         assign in_window   = 1'b1;
      end else begin : g_part_window
         localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(SRAM_BYTES);
         assign in_window = ({1'b0, addr} < LIMIT);
      end
   endgenerate

   // flash enable dominates; SRAM only when flash is idle on the bus
   assign flash_rd = ~flash_en_n & ~oe_n & we_n;
   assign sram_sel = flash_en_n & ~sram_en_n & in_window;
endmodule

// File: rtl/fs_toggle_trk.sv
`timescale 1ns/1ps
module fs_toggle_trk #(
   parameter bit ADVANCE_ON_END = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd,
   input  logic busy,
   output logic tog
);
   logic rd_q;
   logic step;

   generate
      if (ADVANCE_ON_END) begin : g_end_edge
         assign step = rd_q & ~rd;
      end else begin : g_start_edge
         assign step = ~rd_q & rd;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         tog  <= 1'b0;
      end else begin
         rd_q <= rd;
         if (step && busy) tog <= ~tog;
      end
   end

   // R7: idle engine freezes the toggle
   p_frozen_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(tog));

   generate
      if (ADVANCE_ON_END) begin : g_end_chk
         // R7: a read in progress never moves the toggle
         p_steady_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
            rd |=> $stable(tog));
      end
   endgenerate
endmodule

// File: rtl/fs_status_mux.sv
`timescale 1ns/1ps
module fs_status_mux #(
   parameter int DATA_W   = 8,
   parameter int POLL_BIT = 7,
   parameter int TOG_BIT  = 6
) (
   input  logic              busy,
   input  logic              busy_op,
   input  logic              prog_msb,
   input  logic              tog,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rdata
);
   import flash_status_pkg::*;
   logic poll_val;

   assign poll_val = (busy_op_e'(busy_op) == OP_ERASE) ? 1'b0 : ~prog_msb;

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         if (b == POLL_BIT) begin : g_poll
            assign rdata[b] = busy ? poll_val : array_data[b];
         end else if (b == TOG_BIT) begin : g_tog
            assign rdata[b] = busy ? tog : array_data[b];
         end else begin : g_plain
            assign rdata[b] = busy ? 1'b0 : array_data[b];
         end
      end
   endgenerate
endmodule

// File: rtl/flash_status_rdbk.sv
`timescale 1ns/1ps
module flash_status_rdbk #(
   parameter int ADDR_W         = 18,
   parameter int DATA_W         = 8,
   parameter int SRAM_BYTES     = 131072,
   parameter int POLL_BIT       = 7,
   parameter int TOG_BIT        = 6,
   parameter bit ADVANCE_ON_END = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flash_en_n,
   input  logic              sram_en_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              busy,
   input  logic              busy_op,
   input  logic              prog_msb,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic              sram_sel
);
   localparam logic [DATA_W-1:0] STAT_MASK =
      (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOG_BIT);

   generate
      if (POLL_BIT >= DATA_W || TOG_BIT >= DATA_W) begin : g_bad_bits
         $error("status bit position outside data width");
      end
      if (POLL_BIT == TOG_BIT) begin : g_same_bits
         $error("polling and toggle bits must differ");
      end
      if (SRAM_BYTES <= 0 || ADDR_W < 1) begin : g_bad_space
         $error("SRAM window and address width must be positive");
      end
   endgenerate

   logic              flash_rd;
   logic              tog;
   logic [DATA_W-1:0] rdata;

   fs_enable_arb #(.ADDR_W(ADDR_W), .SRAM_BYTES(SRAM_BYTES)) u_arb (
      .flash_en_n (flash_en_n),
      .sram_en_n  (sram_en_n),
      .oe_n       (oe_n),
      .we_n       (we_n),
      .addr       (addr),
      .flash_rd   (flash_rd),
      .sram_sel   (sram_sel)
   );

   fs_toggle_trk #(.ADVANCE_ON_END(ADVANCE_ON_END)) u_tog (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (flash_rd),
      .busy  (busy),
      .tog   (tog)
   );

   fs_status_mux #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_mux (
      .busy       (busy),
      .busy_op    (busy_op),
      .prog_msb   (prog_msb),
      .tog        (tog),
      .array_data (array_data),
      .rdata      (rdata)
   );

   assign dq_oe  = flash_rd;
   assign dq_out = flash_rd ? rdata : '0;

   p_pads_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_n || !we_n || flash_en_n) |-> !dq_oe);
   p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe |-> (dq_out == '0));
   p_flash_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_en_n |-> !sram_sel);
   p_erase_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && busy && busy_op) |-> !dq_out[POLL_BIT]);
   p_prog_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && busy && !busy_op) |-> (dq_out[POLL_BIT] != prog_msb));
   p_low_bits_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && busy) |-> ((dq_out & ~STAT_MASK) == '0));
   p_pass_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && !busy) |-> (dq_out == array_data));
endmodule

// File: tb/sim_flash_status_rdbk.sv
`timescale 1ns/1ps
module sim_flash_status_rdbk;
   localparam int AW = 18;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flash_en_n = 1'b1, sram_en_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          busy = 1'b0, busy_op = 1'b0, prog_msb = 1'b0;
   logic [DW-1:0] array_data = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe, sram_sel;

   always #2 clk = ~clk;

   flash_status_rdbk u0 (
      .clk(clk), .rst_n(rst_n), .flash_en_n(flash_en_n), .sram_en_n(sram_en_n),
      .oe_n(oe_n), .we_n(we_n), .addr(addr), .busy(busy), .busy_op(busy_op),
      .prog_msb(prog_msb), .array_data(array_data), .dq_out(dq_out),
      .dq_oe(dq_oe), .sram_sel(sram_sel)
   );

   int    n_checks = 0;
   int    n_errors = 0;
   bit    exp_tog  = 1'b0;
   bit    done     = 1'b0;
   logic [DW+1:0] exp_q[$];
   string         tag_q[$];
   event          sample_ev;

   // monitor: pops one expected item per sample event
   initial begin
      forever begin
         @(sample_ev);
         while (exp_q.size() > 0) begin
            logic [DW+1:0] e;
            logic [DW+1:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {sram_sel, dq_oe, dq_out};
            n_checks++;
            if (a !== e) begin
               n_errors++;
               $display("FAIL %s: got sel=%b oe=%b dq=%h expected sel=%b oe=%b dq=%h",
                        t, a[DW+1], a[DW], a[DW-1:0], e[DW+1], e[DW], e[DW-1:0]);
            end
         end
      end
   end

   function automatic logic [DW+1:0] model(input logic fl_n, sr_n, o_n, w_n,
                                             input logic [AW-1:0] a);
      logic rd, sel;
      logic [DW-1:0] d;
      rd  = !fl_n && !o_n && w_n;
      sel = fl_n && !sr_n && (a < 18'h20000);
      if (!rd) d = '0;
      else if (busy) d = {(busy_op ? 1'b0 : ~prog_msb), exp_tog, 6'b0};
      else d = array_data;
      return {sel, rd, d};
   endfunction

   // driver: one bus cycle, checked at start and (if long) again before its end
   task automatic cyc(input logic fl_n, sr_n, o_n, w_n, input logic [AW-1:0] a,
                      input int hold, input string tag);
      @(negedge clk);
      flash_en_n = fl_n; sram_en_n = sr_n; oe_n = o_n; we_n = w_n; addr = a;
      #1;
      exp_q.push_back(model(fl_n, sr_n, o_n, w_n, a)); tag_q.push_back(tag);
      -> sample_ev;
      repeat (hold) @(posedge clk);
      if (hold > 1) begin
         @(negedge clk);
         exp_q.push_back(model(fl_n, sr_n, o_n, w_n, a)); tag_q.push_back({tag, " held"});
         -> sample_ev;
      end
      @(negedge clk);
      if (!fl_n && !o_n && w_n && busy) exp_tog = ~exp_tog;
      flash_en_n = 1'b1; sram_en_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_errors++; n_checks++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // idle reads pass array data (R4)
      array_data = 8'hA5;
      cyc(0, 1, 0, 1, 18'h00010, 1, "R4 idle read A5");
      array_data = 8'h3C;
      cyc(0, 1, 0, 1, 18'h21000, 1, "R4 idle read 3C");
      // strobe gating (R1)
      cyc(0, 1, 1, 1, 18'h00010, 1, "R1 oe high");
      cyc(0, 1, 0, 0, 18'h00010, 1, "R1 we low");
      // bank ownership (R2, R3)
      cyc(1, 0, 0, 1, 18'h00100, 1, "R3 sram low half");
      cyc(1, 0, 0, 1, 18'h1FFFF, 1, "R3 sram last byte");
      cyc(1, 0, 0, 1, 18'h20000, 1, "R3 above window");
      cyc(0, 0, 0, 1, 18'h00100, 1, "R2 both enables low");
      // program busy: first read after reset shows toggle 0 (R10, R5, R8)
      busy = 1'b1; busy_op = 1'b0; prog_msb = 1'b0; array_data = 8'hFF;
      cyc(0, 1, 0, 1, 18'h00200, 1, "R10 R5 R8 first status read");
      cyc(0, 1, 0, 1, 18'h00200, 1, "R7 second status read");
      prog_msb = 1'b1;
      cyc(0, 1, 0, 1, 18'h00200, 1, "R5 polling bit for 1");
      // long read holds toggle (R7)
      cyc(0, 1, 0, 1, 18'h00200, 6, "R7 long read");
      cyc(0, 1, 0, 1, 18'h00200, 1, "R7 after long read");
      // SRAM traffic while busy does not advance toggle (R7)
      cyc(1, 0, 0, 1, 18'h00040, 1, "R3 sram during program");
      cyc(0, 1, 0, 1, 18'h00200, 1, "R7 after sram access");
      // erase busy (R6)
      busy_op = 1'b1; prog_msb = 1'b0;
      cyc(0, 1, 0, 1, 18'h03000, 1, "R6 erase poll zero");
      cyc(0, 1, 0, 1, 18'h03000, 1, "R6 R7 erase toggles");
      // busy clears: full data (R9), toggle frozen across idle reads (R7)
      busy = 1'b0; array_data = 8'h5A;
      cyc(0, 1, 0, 1, 18'h03000, 1, "R9 first read after busy");
      cyc(0, 1, 0, 1, 18'h03001, 1, "R9 second idle read");
      busy = 1'b1; busy_op = 1'b0; prog_msb = 1'b0;
      cyc(0, 1, 0, 1, 18'h00300, 1, "R7 toggle frozen while idle");
      cyc(0, 1, 0, 1, 18'h00300, 1, "R7 toggles again");
      busy = 1'b0;
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule